// File: doc/BRIEF.md
# Vertical-Blank Flag and NMI Timing Generator

This block keeps the raster position of a video processor and derives from it the vertical-blank status flag and the interrupt request line toward the CPU. A dot counter runs 0 to 340 and a line counter runs 0 to 261, where line 261 is the pre-render line (the line before line 0). The flag is not set or cleared in a single step. An internal hold bit changes one dot ahead of the flag, and the interrupt line is re-evaluated two dots after the flag. This reproduces the order of events that CPU software can observe.

The CPU reaches the block through a small register port. Address 0 is the control register, and its bit 7 enables the interrupt. Address 2 is the status register. A status read returns the flag together with the two sprite flags and the low bits of the last written byte. The same read clears the whole set/clear pipeline at once and emits a pulse that resets the write toggle in a neighbouring block. A control write re-evaluates the interrupt line immediately, so enabling it during vertical blank raises it at once. On odd frames with rendering enabled, the pre-render line is one dot short.

Top module: `vbl_nmi_gen`

## Requirements
- R1: After reset the position is line 241 dot 0, `nmi` is 0, `odd_frame` is 0, `toggle_clr` is 0 and status bit 7 reads 0.
- R2: The dot counter counts 0..340 and the line counter counts 0..261. A line lasts 341 clocks, and with rendering off the first frame boundary (line 0 dot 0) is reached 7161 clocks after reset.
- R3: `odd_frame` toggles only when the position becomes line 0 dot 0. On an odd frame where `render_en` was high at line 261 dot 337, line 261 goes from dot 339 directly to line 0 dot 0, so that frame lasts 89341 clocks.
- R4: The hold bit is loaded with 1 at the edge that ends line 240 dot 340. The flag is loaded from hold at the edge that ends line 241 dot 0. `nmi` is loaded with enable AND flag at the edge that ends line 241 dot 2, so with the interrupt enabled `nmi` is first high at line 241 dot 3.
- R5: The hold bit is loaded with 0 at the edge that ends line 260 dot 340. The flag is loaded from hold at the edge that ends line 261 dot 0. `nmi` is re-evaluated at the edge that ends line 261 dot 2, so it is first low at line 261 dot 3.
- R6: While `reg_rd` is high with `reg_addr` = 2, `rd_data` in the same cycle is {flag, `spr0_hit`, `spr_ovf`, last written byte bits 4:0}, with the flag in bit 7. A read of any other address returns the last written byte.
- R7: Every write, to any address, replaces the stored last written byte.
- R8: A status read clears the flag, the hold bit and `nmi` at its clock edge. `toggle_clr` is high for exactly the one cycle after the read.
- R9: A write to address 0 loads the interrupt enable from data bit 7 and sets `nmi` to enable AND hold AND flag at that edge. Enabling during vertical blank raises `nmi` on the next cycle, and disabling drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe, one cycle per read |
| reg_addr | input | 3 | Register address: 0 control, 2 status |
| reg_wdata | input | 8 | Write data |
| spr0_hit | input | 1 | Sprite-zero hit flag from the sprite logic |
| spr_ovf | input | 1 | Sprite overflow flag from the sprite logic |
| render_en | input | 1 | Rendering enabled (background or sprites) |
| rd_data | output | 8 | Read data, valid in the cycle `reg_rd` is high |
| nmi | output | 1 | Interrupt request line, active high |
| toggle_clr | output | 1 | One-cycle pulse resetting the write toggle |
| dot | output | 9 | Current dot, 0..340 |
| line | output | 9 | Current line, 0..261 (261 = pre-render) |
| odd_frame | output | 1 | Frame parity |

## Verification
Each state change lands one clock after the position or access that causes it. The hold bit, the flag and `nmi` are registered at the edge that ends the named dot, so the bench waits until the `line`/`dot` ports show the position after it and samples on the falling edge. `rd_data` is combinational and is sampled mid-cycle while the read strobe is still high. `toggle_clr` and the `nmi` effects of a read or write are sampled on the falling edge after the access ends. Frame and line lengths are measured by counting rising edges between two observed positions.

// File: rtl/vbt_pkg.sv
// Shared definitions for the vertical-blank/NMI generator.
// Assumes a register port with a single access per cycle.
package vbt_pkg;

    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd2;

    // Position-driven actions on the hold/flag/nmi pipeline
    typedef struct packed {
        logic hold_ld;   // load hold bit with hold_val
        logic hold_val;
        logic flag_ld;   // copy hold into flag
        logic nmi_eval;  // nmi <= enable & flag
    } vbl_evt_t;

endpackage

// File: rtl/vbt_raster.sv
// Dot/line raster counter with odd-frame short pre-render line.
// Assumes LINES-1 is the pre-render line and line 0 follows it.
// The render enable is sampled once per frame at SAMPLE_DOT of that line.
module vbt_raster #(
    parameter int DOTS       = 341,
    parameter int LINES      = 262,
    parameter int START_LINE = 241,
    parameter int SAMPLE_DOT = 337,
    parameter int DOT_W      = 9,
    parameter int LINE_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              render_en,
    output logic [DOT_W-1:0]  dot_o,
    output logic [LINE_W-1:0] line_o,
    output logic              odd_o
);
    localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS - 1);
    localparam logic [DOT_W-1:0]  SHORT_DOT = DOT_W'(DOTS - 2);
    localparam logic [DOT_W-1:0]  SMP_DOT   = DOT_W'(SAMPLE_DOT);
    localparam logic [LINE_W-1:0] PRE_LINE  = LINE_W'(LINES - 1);
    localparam logic [LINE_W-1:0] RST_LINE  = LINE_W'(START_LINE);

    logic [DOT_W-1:0]  dot_q;
    logic [LINE_W-1:0] line_q;
    logic              odd_q;
    logic              render_smp;
    logic              on_pre;
    logic              skip_now;
    logic              line_end;

    // Decide whether the current dot is the last one of its line
    always_comb begin
        on_pre   = (line_q == PRE_LINE);
        skip_now = on_pre && odd_q && render_smp && (dot_q == SHORT_DOT);
        line_end = (dot_q == LAST_DOT) || skip_now;
    end

    // Capture the render enable at the sample dot of the pre-render line
    always_ff @(posedge clk) begin
        if (!rst_n)
            render_smp <= 1'b0;
        else if (on_pre && dot_q == SMP_DOT)
            render_smp <= render_en;
    end

    // Advance dot, line and frame parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_q  <= '0;
            line_q <= RST_LINE;
            odd_q  <= 1'b0;
        end else if (line_end) begin
            dot_q <= '0;
            if (on_pre) begin
                line_q <= '0;
                odd_q  <= ~odd_q;
            end else begin
                line_q <= line_q + 1'b1;
            end
        end else begin
            dot_q <= dot_q + 1'b1;
        end
    end

    assign dot_o  = dot_q;
    assign line_o = line_q;
    assign odd_o  = odd_q;

    // R2
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_q <= LAST_DOT) && (line_q <= PRE_LINE));

    // R3
    parity_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_q != $past(odd_q)) |-> (line_q == '0 && dot_q == '0));

    // R3
    short_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_pre && dot_q == LAST_DOT) |-> !(odd_q && render_smp));

endmodule

// File: rtl/vbt_event_dec.sv
// Decodes the raster position into hold/flag/nmi pipeline actions.
// Set and clear sequences mirror each other: hold one dot before the
// flag, nmi evaluation NMI_GAP dots after the flag.
module vbt_event_dec
    import vbt_pkg::*;
#(
    parameter int DOTS     = 341,
    parameter int LINES    = 262,
    parameter int SET_LINE = 241,
    parameter int NMI_GAP  = 2,
    parameter int DOT_W    = 9,
    parameter int LINE_W   = 9
) (
    input  logic [DOT_W-1:0]  dot_i,
    input  logic [LINE_W-1:0] line_i,
    output vbl_evt_t          evt_o
);
    localparam logic [DOT_W-1:0]  LAST_DOT = DOT_W'(DOTS - 1);
    localparam logic [DOT_W-1:0]  NMI_DOT  = DOT_W'(NMI_GAP);
    localparam logic [LINE_W-1:0] SET_L    = LINE_W'(SET_LINE);
    localparam logic [LINE_W-1:0] HSET_L   = LINE_W'(SET_LINE - 1);
    localparam logic [LINE_W-1:0] CLR_L    = LINE_W'(LINES - 1);
    localparam logic [LINE_W-1:0] HCLR_L   = LINE_W'(LINES - 2);

    logic hold_set, hold_clr, flag_pt, nmi_pt;

    // Match the six pipeline positions
    always_comb begin
        hold_set = (line_i == HSET_L) && (dot_i == LAST_DOT);
        hold_clr = (line_i == HCLR_L) && (dot_i == LAST_DOT);
        flag_pt  = ((line_i == SET_L) || (line_i == CLR_L)) && (dot_i == '0);
        nmi_pt   = ((line_i == SET_L) || (line_i == CLR_L)) && (dot_i == NMI_DOT);
        evt_o.hold_ld  = hold_set || hold_clr;
        evt_o.hold_val = hold_set;
        evt_o.flag_ld  = flag_pt;
        evt_o.nmi_eval = nmi_pt;
    end

endmodule

// File: rtl/vbt_flag_pipe.sv
// Hold bit, vertical-blank flag and interrupt line.
// A status read clears all three stages and wins over a same-cycle event.
// A control write re-evaluates nmi from enable, hold and flag at once.
module vbt_flag_pipe
    import vbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  vbl_evt_t evt_i,
    input  logic     stat_rd_i,
    input  logic     ctrl_wr_i,
    input  logic     ctrl_en_i,
    output logic     flag_o,
    output logic     nmi_o
);
    logic hold_q, flag_q, nmi_q, en_q;

    // Hold stage: loaded by position, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n || stat_rd_i)
            hold_q <= 1'b0;
        else if (evt_i.hold_ld)
            hold_q <= evt_i.hold_val;
    end

    // Flag stage: follows hold one dot later
    always_ff @(posedge clk) begin
        if (!rst_n || stat_rd_i)
            flag_q <= 1'b0;
        else if (evt_i.flag_ld)
            flag_q <= hold_q;
    end

    // Interrupt enable from control bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (ctrl_wr_i)
            en_q <= ctrl_en_i;
    end

    // Interrupt line: immediate on control write, else at evaluation dot
    always_ff @(posedge clk) begin
        if (!rst_n || stat_rd_i)
            nmi_q <= 1'b0;
        else if (ctrl_wr_i)
            nmi_q <= ctrl_en_i && hold_q && flag_q;
        else if (evt_i.nmi_eval)
            nmi_q <= en_q && flag_q;
    end

    assign flag_o = flag_q;
    assign nmi_o  = nmi_q;

    // R4
    flag_from_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(hold_q) && $past(evt_i.flag_ld));

    // R5
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(stat_rd_i) || $past(evt_i.flag_ld));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i |=> !flag_q && !hold_q && !nmi_q);

    // R9
    nmi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_q) |-> $past(ctrl_wr_i) || $past(evt_i.nmi_eval));

endmodule

// File: rtl/vbt_reg_port.sv
// CPU register port: strobe decode, last-written byte, status read mux
// and the write-toggle reset pulse. Assumes one access per cycle.
module vbt_reg_port
    import vbt_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          flag_i,
    input  logic          spr0_i,
    input  logic          ovf_i,
    output logic          stat_rd_o,
    output logic          ctrl_wr_o,
    output logic [DW-1:0] rd_data_o,
    output logic          toggle_clr_o
);
    localparam int LOW_W = DW - 3;

    logic [DW-1:0] last_wr_q;
    logic          toggle_q;

    // Decode access strobes
    always_comb begin
        stat_rd_o = reg_rd && (reg_addr == AW'(ADDR_STAT));
        ctrl_wr_o = reg_wr && (reg_addr == AW'(ADDR_CTRL));
    end

    // Keep the last byte written to any register
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_wr_q <= '0;
        else if (reg_wr)
            last_wr_q <= reg_wdata;
    end

    // One-cycle toggle reset after a status read
    always_ff @(posedge clk) begin
        if (!rst_n)
            toggle_q <= 1'b0;
        else
            toggle_q <= stat_rd_o;
    end

    // Read data mux
    always_comb begin
        if (!reg_rd)
            rd_data_o = '0;
        else if (stat_rd_o)
            rd_data_o = {flag_i, spr0_i, ovf_i, last_wr_q[LOW_W-1:0]};
        else
            rd_data_o = last_wr_q;
    end

    assign toggle_clr_o = toggle_q;

    // R8
    toggle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_o |=> toggle_q ##1 !$past(stat_rd_o) || toggle_q);

    // R7
    last_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> last_wr_q == $past(reg_wdata));

    // R6
    single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

endmodule

// File: rtl/vbl_nmi_gen.sv
// Top of the vertical-blank flag and NMI timing generator.
// Owns the raster position; the CPU port reads status and writes control.
module vbl_nmi_gen
    import vbt_pkg::*;
#(
    parameter int DOTS       = 341,
    parameter int LINES      = 262,
    parameter int SET_LINE   = 241,
    parameter int NMI_GAP    = 2,
    parameter int SAMPLE_DOT = 337,
    parameter int DW         = DATA_W,
    parameter int AW         = ADDR_W,
    parameter int DOT_W      = $clog2(DOTS),
    parameter int LINE_W     = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              spr0_hit,
    input  logic              spr_ovf,
    input  logic              render_en,
    output logic [DW-1:0]     rd_data,
    output logic              nmi,
    output logic              toggle_clr,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line,
    output logic              odd_frame
);
    vbl_evt_t evt;
    logic     stat_rd, ctrl_wr, flag;

    vbt_raster #(
        .DOTS(DOTS), .LINES(LINES), .START_LINE(SET_LINE),
        .SAMPLE_DOT(SAMPLE_DOT), .DOT_W(DOT_W), .LINE_W(LINE_W)
    ) u_raster (
        .clk(clk), .rst_n(rst_n), .render_en(render_en),
        .dot_o(dot), .line_o(line), .odd_o(odd_frame)
    );

    vbt_event_dec #(
        .DOTS(DOTS), .LINES(LINES), .SET_LINE(SET_LINE),
        .NMI_GAP(NMI_GAP), .DOT_W(DOT_W), .LINE_W(LINE_W)
    ) u_dec (
        .dot_i(dot), .line_i(line), .evt_o(evt)
    );

    vbt_flag_pipe u_pipe (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .stat_rd_i(stat_rd), .ctrl_wr_i(ctrl_wr),
        .ctrl_en_i(reg_wdata[DW-1]),
        .flag_o(flag), .nmi_o(nmi)
    );

    vbt_reg_port #(.DW(DW), .AW(AW)) u_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .flag_i(flag), .spr0_i(spr0_hit), .ovf_i(spr_ovf),
        .stat_rd_o(stat_rd), .ctrl_wr_o(ctrl_wr),
        .rd_data_o(rd_data), .toggle_clr_o(toggle_clr)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (nmi == 1'b0) && (odd_frame == 1'b0) && (dot == '0));

endmodule

// File: tb/sim_vbl_nmi_gen.sv
module sim_vbl_nmi_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       spr0_hit = 1'b0, spr_ovf = 1'b0, render_en = 1'b0;
    logic [7:0] rd_data;
    logic       nmi, toggle_clr, odd_frame;
    logic [8:0] dot, line;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vbl_nmi_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .spr0_hit(spr0_hit),
        .spr_ovf(spr_ovf), .render_en(render_en), .rd_data(rd_data),
        .nmi(nmi), .toggle_clr(toggle_clr), .dot(dot), .line(line),
        .odd_frame(odd_frame)
    );

    // {line, dot, expected nmi} sampled while the position is shown
    localparam logic [18:0] VEC [10] = '{
        {9'd240, 9'd340, 1'b0}, {9'd241, 9'd0,   1'b0},
        {9'd241, 9'd2,   1'b0}, {9'd241, 9'd3,   1'b1},
        {9'd241, 9'd100, 1'b1}, {9'd260, 9'd340, 1'b1},
        {9'd261, 9'd0,   1'b1}, {9'd261, 9'd2,   1'b1},
        {9'd261, 9'd3,   1'b0}, {9'd261, 9'd10,  1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_pos(input int l, input int d);
        while (!(int'(line) == l && int'(dot) == d)) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #2 v = rd_data;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 198000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int t0, t1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t0 = cyc;
        // R1 reset state
        chk("R1 line", int'(line), 241);
        chk("R1 dot", int'(dot), 0);
        chk("R1 nmi", int'(nmi), 0);
        chk("R1 odd", int'(odd_frame), 0);
        chk("R1 toggle", int'(toggle_clr), 0);
        // R7/R6 status composition
        wr(3'd5, 8'h35);
        spr0_hit = 1'b1; spr_ovf = 1'b0;
        rd(3'd2, v);
        chk("R6 status", int'(v), 8'h55);
        chk("R8 toggle pulse", int'(toggle_clr), 1);
        @(negedge clk);
        chk("R8 toggle single", int'(toggle_clr), 0);
        spr0_hit = 1'b0; spr_ovf = 1'b1;
        rd(3'd2, v);
        chk("R6 status ovf", int'(v), 8'h35);
        rd(3'd7, v);
        chk("R6 other addr", int'(v), 8'h35);
        wr(3'd3, 8'hCA);
        rd(3'd2, v);
        chk("R7 any write", int'(v), 8'h2A);
        // R9 enable outside vblank does not fire
        wr(3'd0, 8'h80);
        chk("R9 no vblank", int'(nmi), 0);
        wr(3'd0, 8'h00);
        // R2 first frame boundary and line length
        wait_pos(0, 0);
        chk("R2 to boundary", cyc - t0, 7161);
        chk("R3 parity", int'(odd_frame), 1);
        render_en = 1'b1;
        t1 = cyc;
        wait_pos(1, 0);
        chk("R2 line length", cyc - t1, 341);
        // First vblank: late enable, disable, read clear
        wait_pos(241, 3);
        chk("R4 disabled", int'(nmi), 0);
        wait_pos(241, 20);
        wr(3'd0, 8'h80);
        chk("R9 late enable", int'(nmi), 1);
        wait_pos(241, 40);
        wr(3'd0, 8'h00);
        chk("R9 disable", int'(nmi), 0);
        wait_pos(241, 60);
        wr(3'd0, 8'h80);
        chk("R9 re-enable", int'(nmi), 1);
        wait_pos(250, 0);
        rd(3'd2, v);
        chk("R4 flag set", int'(v[7]), 1);
        chk("R8 nmi cleared", int'(nmi), 0);
        rd(3'd2, v);
        chk("R8 flag cleared", int'(v[7]), 0);
        wr(3'd0, 8'h80);
        chk("R8 stages cleared", int'(nmi), 0);
        // R3 odd frame short pre-render line
        wait_pos(261, 339);
        @(negedge clk);
        chk("R3 skip line", int'(line), 0);
        chk("R3 skip dot", int'(dot), 0);
        chk("R3 odd length", cyc - t1, 89341);
        chk("R3 parity back", int'(odd_frame), 0);
        // Second vblank: R4/R5 timing walk
        for (int i = 0; i < 10; i++) begin
            wait_pos(int'(VEC[i][18:10]), int'(VEC[i][9:1]));
            chk((int'(VEC[i][18:10]) == 241) ? "R4 nmi timing" : "R5 nmi timing",
                int'(nmi), int'(VEC[i][0]));
        end
        wait_pos(261, 20);
        rd(3'd2, v);
        chk("R5 flag cleared", int'(v[7]), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule